// File: doc/BRIEF.md
# Trap Sequencer with Fault Address and Cause Capture

This block is the control sequencer of a multicycle processor, extended with two fault states. It walks each instruction through fetch, decode and the execution steps its opcode calls for. It detects two internal faults. The first is an opcode that belongs to no supported instruction class. The second is an arithmetic overflow reported by the ALU while a register-register operation executes. On either fault it records the address of the faulting instruction and a reason code, and it steers the program counter to a fixed trap vector. After that it resumes with a new fetch.

The surrounding datapath supplies the opcode held in its instruction register, the ALU overflow flag and the current program counter. The program counter has already been advanced past the instruction at fetch. The block returns the saved fault address, the reason code, one write strobe for each of those two registers, a register-file write strobe and a 2-bit program-counter source select. The datapath uses that select to choose among the sequential address, the branch target, the jump target and the trap vector. All strobes are decoded from the state register only, so no input reaches an output in the same cycle.

Top module: `exc_unit`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the fetch step and clears the fault address and reason registers. In the reset state every strobe is low and the PC source select is 00. Reset takes priority over a capture in the same cycle.
- R2: The instruction lengths, counted from fetch to the last step before the next fetch, are: opcode 0x23 (load) 5 cycles, 0x2B (store) 4 cycles, 0x00 (register-register) 4 cycles, 0x04 (branch) 3 cycles and 0x02 (jump) 3 cycles. The PC source select is 00 in fetch, 01 in the branch completion step and 10 in the jump completion step.
- R3: Any other opcode, sampled in the decode step, leads to the undefined-instruction fault step. That instruction lasts 3 cycles.
- R4: An ALU overflow sampled in the register-register execute step leads to the overflow fault step in place of writeback. The overflow input has no effect in any other step.
- R5: The register-file write strobe is high for exactly one cycle in the writeback step of a register-register operation or a load. It is never high for a store, a branch, a jump or any faulting instruction.
- R6: The fault-address write strobe and the reason write strobe are high together for exactly one cycle, and only in a fault step.
- R7: At the end of a fault step the fault-address register loads the current PC minus 4, modulo 2^32. At all other times it holds its value.
- R8: At the end of a fault step the reason register loads 0 for an undefined instruction or 1 for an overflow, zero-extended to 32 bits. At all other times it holds its value.
- R9: In both fault steps the PC source select is 11, and the trap vector output reads 0x8000_0180. The next step is fetch.
- R10: An undefined opcode takes priority over overflow. It gives reason 0 even while the overflow input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_ovf | input | 1 | ALU signed-overflow flag |
| pc | input | 32 | Current program counter, already advanced at fetch |
| epc | output | 32 | Saved fault address |
| cause | output | 32 | Fault reason code |
| epc_wr | output | 1 | Fault-address register write strobe |
| cause_wr | output | 1 | Reason register write strobe |
| pc_src | output | 2 | PC source select: 00 sequential, 01 branch, 10 jump, 11 trap |
| rf_wr | output | 1 | Register-file write strobe |
| trap_pc | output | 32 | Trap vector address |

## Verification
The assertions check several properties on every cycle. The two capture strobes last a single cycle, coincide with the trap select and are followed by fetch. The fault address equals the previous cycle's PC minus 4 after a capture and holds otherwise. The reason register stays within 0 and 1. A register-file write never coincides with a fault. Only the bench's instruction scenarios can show the things that depend on which opcode or flag came in. These are the instruction lengths, the branch and jump selects, the reason value chosen for each fault, the priority of an undefined opcode over overflow, that overflow has no effect outside register-register execution, and that reset overrides a capture already under way.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int OPW = 6;

  localparam logic [OPW-1:0] OP_RTYPE  = 6'h00;
  localparam logic [OPW-1:0] OP_JUMP   = 6'h02;
  localparam logic [OPW-1:0] OP_BEQ    = 6'h04;
  localparam logic [OPW-1:0] OP_LOAD   = 6'h23;
  localparam logic [OPW-1:0] OP_STORE  = 6'h2B;

  typedef enum logic [2:0] {
    CLS_RTYPE, CLS_LOAD, CLS_STORE, CLS_BRANCH, CLS_JUMP, CLS_ILLEGAL
  } op_class_t;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MADDR, ST_MREAD, ST_MWB, ST_MWRITE,
    ST_REXEC, ST_RWB, ST_BRANCH, ST_JUMP, ST_XUNDEF, ST_XOVF
  } ctl_state_t;

  typedef enum logic [1:0] {
    PCS_SEQ    = 2'b00,
    PCS_BRANCH = 2'b01,
    PCS_JUMP   = 2'b10,
    PCS_TRAP   = 2'b11
  } pc_sel_t;
endpackage

// File: rtl/exc_opdecode.sv
module exc_opdecode
  import exc_pkg::*;
(
  input  logic [OPW-1:0] op,
  output op_class_t      cls
);
  always_comb begin
    unique case (op)
      OP_RTYPE: cls = CLS_RTYPE;
      OP_LOAD:  cls = CLS_LOAD;
      OP_STORE: cls = CLS_STORE;
      OP_BEQ:   cls = CLS_BRANCH;
      OP_JUMP:  cls = CLS_JUMP;
      default:  cls = CLS_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  op_class_t  cls,
  input  logic       alu_ovf,
  output ctl_state_t state,
  output pc_sel_t    pc_sel,
  output logic       rf_we,
  output logic       trap_we,
  output logic       trap_is_ovf
);
  ctl_state_t state_q, state_d;
  op_class_t  cls_q;

  // The class is kept from decode so that the memory steps can tell load from store.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      cls_q   <= CLS_RTYPE;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE) cls_q <= cls;
    end
  end

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (cls)
          CLS_RTYPE:            state_d = ST_REXEC;
          CLS_LOAD, CLS_STORE:  state_d = ST_MADDR;
          CLS_BRANCH:           state_d = ST_BRANCH;
          CLS_JUMP:             state_d = ST_JUMP;
          default:              state_d = ST_XUNDEF; // caught before any execute step
        endcase
      end
      ST_MADDR:  state_d = (cls_q == CLS_LOAD) ? ST_MREAD : ST_MWRITE;
      ST_MREAD:  state_d = ST_MWB;
      ST_REXEC:  state_d = alu_ovf ? ST_XOVF : ST_RWB; // overflow replaces writeback
      default:   state_d = ST_FETCH;
    endcase
  end

  // Moore decode: outputs depend on the state register only.
  always_comb begin
    pc_sel      = PCS_SEQ;
    rf_we       = 1'b0;
    trap_we     = 1'b0;
    trap_is_ovf = 1'b0;
    unique case (state_q)
      ST_BRANCH: pc_sel = PCS_BRANCH;
      ST_JUMP:   pc_sel = PCS_JUMP;
      ST_RWB, ST_MWB: rf_we = 1'b1;
      ST_XUNDEF: begin
        pc_sel  = PCS_TRAP;
        trap_we = 1'b1;
      end
      ST_XOVF: begin
        pc_sel      = PCS_TRAP;
        trap_we     = 1'b1;
        trap_is_ovf = 1'b1;
      end
      default: ;
    endcase
  end

  assign state = state_q;
endmodule

// File: rtl/exc_capture.sv
module exc_capture #(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            is_ovf,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  logic [XLEN-1:0] fault_addr;
  logic [XLEN-1:0] code;

  // The PC was advanced at fetch; step back to the faulting instruction.
  assign fault_addr = pc - STEP;
  assign code       = {{(XLEN-1){1'b0}}, is_ovf};

  always_ff @(posedge clk) begin
    if (rst) begin
      epc   <= '0;
      cause <= '0;
    end else if (we) begin
      epc   <= fault_addr;
      cause <= code;
    end
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit #(
  parameter int              XLEN      = 32,
  parameter int              PC_STEP   = 4,
  parameter logic [XLEN-1:0] TRAP_ADDR = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [5:0]      opcode,
  input  logic            alu_ovf,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause,
  output logic            epc_wr,
  output logic            cause_wr,
  output logic [1:0]      pc_src,
  output logic            rf_wr,
  output logic [XLEN-1:0] trap_pc
);
  import exc_pkg::*;

  op_class_t  cls;
  ctl_state_t state;
  pc_sel_t    pc_sel;
  logic       rf_we, trap_we, trap_is_ovf;

  exc_opdecode u_dec (
    .op  (opcode),
    .cls (cls)
  );

  exc_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .cls         (cls),
    .alu_ovf     (alu_ovf),
    .state       (state),
    .pc_sel      (pc_sel),
    .rf_we       (rf_we),
    .trap_we     (trap_we),
    .trap_is_ovf (trap_is_ovf)
  );

  exc_capture #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .we     (trap_we),
    .is_ovf (trap_is_ovf),
    .pc     (pc),
    .epc    (epc),
    .cause  (cause)
  );

  assign epc_wr   = trap_we;
  assign cause_wr = trap_we;
  assign pc_src   = pc_sel;
  assign rf_wr    = rf_we;
  assign trap_pc  = TRAP_ADDR;

  logic unused_state;
  assign unused_state = ^state;
endmodule

// File: rtl/exc_unit_checks.sv
module exc_unit_checks (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] epc,
  input logic [31:0] cause,
  input logic        epc_wr,
  input logic        cause_wr,
  input logic [1:0]  pc_src,
  input logic        rf_wr
);
  // R6: the two capture strobes last one cycle
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    epc_wr |=> !epc_wr && !cause_wr);

  // R6 and R9: a capture happens only together with the trap select
  p_strobe_trap_r9: assert property (@(posedge clk) disable iff (rst)
    (epc_wr || cause_wr) |-> pc_src == 2'b11);

  // R9: fetch follows a fault step
  p_fetch_next_r9: assert property (@(posedge clk) disable iff (rst)
    epc_wr |=> pc_src == 2'b00);

  // R7: the saved address is the previous cycle's PC minus 4
  p_epc_value_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(epc_wr) && !$past(rst)) |-> epc == $past(pc) - 32'd4);

  // R7: the saved address holds without a strobe
  p_epc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(epc_wr)) |-> $stable(epc));

  // R8: the reason register holds without a strobe and stays 0 or 1
  p_cause_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cause_wr)) |-> $stable(cause));
  p_cause_range_r8: assert property (@(posedge clk) disable iff (rst)
    cause[31:1] == 31'd0);

  // R5: no register write in a fault step
  p_no_rfwr_fault_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_wr, epc_wr}));
endmodule

bind exc_unit exc_unit_checks u_checks (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc),
  .epc      (epc),
  .cause    (cause),
  .epc_wr   (epc_wr),
  .cause_wr (cause_wr),
  .pc_src   (pc_src),
  .rf_wr    (rf_wr)
);

// File: tb/test_exc_unit.sv
`timescale 1ns/1ps
module test_exc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  opcode;
  logic        alu_ovf;
  logic [31:0] pc;
  logic [31:0] epc, cause, trap_pc;
  logic        epc_wr, cause_wr, rf_wr;
  logic [1:0]  pc_src;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [31:0] exp_epc = '0;
  logic [31:0] exp_cause = '0;

  always #10 clk = ~clk;

  exc_unit i_exc_unit (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf), .pc(pc),
    .epc(epc), .cause(cause), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .pc_src(pc_src), .rf_wr(rf_wr), .trap_pc(trap_pc)
  );

  // Vector table. Fault kind: 0 none, 1 undefined, 2 overflow.
  localparam int NV = 11;
  localparam logic [5:0]  V_OP  [NV] = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h02, 6'h3F,
                                         6'h00, 6'h08, 6'h23, 6'h01, 6'h2B};
  localparam logic        V_OVF [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                         1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] V_PC  [NV] = '{32'h0040_0004, 32'h0040_0008, 32'h0040_000C,
                                         32'h0040_0010, 32'h0040_0014, 32'h0040_0020,
                                         32'h0040_0018, 32'h0000_0004, 32'h0040_0030,
                                         32'h0000_0000, 32'h0040_0040};
  localparam int          V_LEN [NV] = '{4, 5, 4, 3, 3, 3, 4, 3, 5, 3, 4};
  localparam logic [1:0]  V_SRC [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3,
                                         2'd3, 2'd3, 2'd0, 2'd3, 2'd0};
  localparam int          V_EXC [NV] = '{0, 0, 0, 0, 0, 1, 2, 1, 0, 1, 0};
  localparam int          V_RFW [NV] = '{1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at the falling edge of a fetch cycle; returns at the next fetch.
  task automatic run_instr(input logic [5:0] op, input logic ovf, input logic [31:0] pcv,
                           input int len, input logic [1:0] src, input int exc,
                           input int rfw, input string tag);
    int n_trap = 0;
    int n_rf = 0;
    logic [1:0] last_src = 2'b00;
    logic [31:0] tpc = '0;
    opcode  = op;
    alu_ovf = ovf;
    pc      = pcv;
    for (int c = 0; c < len; c++) begin
      if (c > 0) @(negedge clk);
      if (c == 0)
        chk(pc_src == 2'b00 && !epc_wr && !rf_wr, {"R2 fetch step ", tag},
            {29'd0, rf_wr, pc_src}, 32'd0);
      if (epc_wr && cause_wr) n_trap++;
      if (epc_wr != cause_wr) n_trap += 10;
      if (rf_wr) n_rf++;
      if (pc_src == 2'b11) tpc = trap_pc;
      last_src = pc_src;
    end
    chk(last_src == src, {"R2/R9 last-step PC select ", tag}, {30'd0, last_src}, {30'd0, src});
    chk(n_trap == (exc != 0 ? 1 : 0), {"R6/R3/R4 capture strobes ", tag}, n_trap,
        (exc != 0) ? 32'd1 : 32'd0);
    chk(n_rf == rfw, {"R5 register write count ", tag}, n_rf, rfw);
    if (exc != 0) begin
      chk(tpc == 32'h8000_0180, {"R9 trap vector ", tag}, tpc, 32'h8000_0180);
      exp_epc   = pcv - 32'd4;
      exp_cause = (exc == 2) ? 32'd1 : 32'd0;
    end
    @(negedge clk);
    chk(pc_src == 2'b00 && !epc_wr, {"R2/R9 back at fetch ", tag}, {30'd0, pc_src}, 32'd0);
    chk(epc == exp_epc, {"R7 saved address ", tag}, epc, exp_epc);
    chk(cause == exp_cause, {"R8/R10 reason ", tag}, cause, exp_cause);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; opcode = 6'h00; alu_ovf = 1'b0; pc = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(epc == 32'd0 && cause == 32'd0, "R1 registers cleared", epc | cause, 32'd0);
    chk(!epc_wr && !cause_wr && !rf_wr && pc_src == 2'b00, "R1 strobes low",
        {28'd0, epc_wr, cause_wr, rf_wr, |pc_src}, 32'd0);
    rst = 1'b0;

    // Table walk: every class, both faults, R10 priority, R4 ignored overflow, PC wrap for R7
    for (int i = 0; i < NV; i++)
      run_instr(V_OP[i], V_OVF[i], V_PC[i], V_LEN[i], V_SRC[i], V_EXC[i], V_RFW[i],
                $sformatf("vec%0d", i));

    // R1: reset during a fault step overrides the capture
    opcode = 6'h3F; alu_ovf = 1'b0; pc = 32'h0000_0100;
    @(negedge clk);
    @(negedge clk);
    chk(epc_wr == 1'b1, "R3 undefined fault step reached", {31'd0, epc_wr}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk(epc == 32'd0 && cause == 32'd0, "R1 reset beats capture", epc, 32'd0);
    chk(pc_src == 2'b00 && !epc_wr, "R1 reset returns to fetch", {30'd0, pc_src}, 32'd0);
    rst = 1'b0;
    exp_epc = '0; exp_cause = '0;
    run_instr(6'h04, 1'b1, 32'h0000_0200, 3, 2'd1, 0, 0, "post-reset branch");
    run_instr(6'h00, 1'b1, 32'h0000_0300, 4, 2'd3, 2, 0, "post-reset overflow");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule